// File: doc/BRIEF.md
# Committed Store Drain Engine

This block holds the stores of an out-of-order core between dispatch and memory and drains the committed ones to a data cache. Stores are appended at the tail with their sequence number and attributes. A commit input names the youngest retired sequence number. The engine then flags the matching stores as ready to drain. A separate drain pointer, which sits between head and tail, walks the ready stores in program order. It hands out up to `PORTS` cache write requests per cycle.

Several special cases are handled on the way. A store of zero bytes finishes without touching the cache. A prefetch entry takes a cache slot but sends nothing. A store that crosses a line is split into two halves, and if the second half finds no free slot it goes out first in the next cycle. A store-conditional whose reservation is lost finishes at once, and its failure is reported one cycle later. When the cache refuses a request, that request is parked in a single retry register and draining stops until the cache signals a retry. Finished entries free the head in order.

Top module: `sqwb_engine`

## Requirements
- R1: `alloc_valid` appends one entry at the tail when fewer than `DEPTH` entries are held. `sq_full` is high exactly when `sq_count` equals `DEPTH`, and an allocation while full leaves `sq_count` unchanged.
- R2: A `commit_valid` pulse walks from the head and flags each not-yet-flagged entry whose sequence number is at most `commit_seq`. The walk stops at the first unflagged entry whose number is larger. `wb_pending` grows by the number of entries flagged, and an unflagged entry never produces a request.
- R3: Flagged entries issue in queue order, at most `PORTS` per cycle, filling slot 0 upward. `wr_kind` is 2'b00 for a plain write, 2'b01 for a store-conditional and 2'b10 for a swap. A first or only half has `wr_half` = 0.
- R4: A zero-size entry completes as soon as the drain pointer reaches it, consumes no slot, and never appears on `wr_valid`.
- R5: A prefetch entry consumes a slot that stays invalid and completes without a request.
- R6: A split entry issues half 0 and then half 1 in the next slot of the same cycle when a slot is free. Otherwise half 1 goes out in slot 0 of the next cycle, ahead of any other entry.
- R7: While `cache_busy` is high, no request is driven and no entry completes.
- R8: A valid slot with `wr_accept` low is parked, and no later slot is valid in that cycle. No request is driven until a cycle with `retry` high, in which the parked request appears in slot 0 and draining resumes behind it. An entry completes only when its last half is accepted.
- R9: A store-conditional reached while `link_ok` is low consumes a slot, issues nothing, and completes. The cycle after, `scfail_valid` is high with its index in `scfail_idx`. Draining stops for the rest of that cycle.
- R10: On the edge where an entry completes, the head moves past every consecutive completed entry up to the tail. `sq_count` and `wb_pending` each drop by the number of entries retired.
- R11: After reset the queue is empty, `sq_full`, `wr_valid`, `scfail_valid` and `wb_pending` are zero, and the head index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Append a store at the tail |
| alloc_seq | input | SEQW | Sequence number of the appended store |
| alloc_size | input | SZW | Byte count; zero means no memory access |
| alloc_split | input | 1 | Store is sent as two halves |
| alloc_prefetch | input | 1 | Entry is a prefetch |
| alloc_cond | input | 1 | Entry is a store-conditional |
| alloc_swap | input | 1 | Entry is a swap |
| sq_full | output | 1 | Queue holds DEPTH entries |
| commit_valid | input | 1 | Commit walk request |
| commit_seq | input | SEQW | Youngest committed sequence number |
| cache_busy | input | 1 | Cache cannot take requests this cycle |
| link_ok | input | 1 | Reservation for store-conditionals still held |
| retry | input | 1 | Cache asks for the parked request again |
| wr_accept | input | PORTS | Per-slot acceptance, same cycle |
| wr_valid | output | PORTS | Per-slot request valid |
| wr_idx | output | PORTS*IW | Per-slot queue index |
| wr_half | output | PORTS | Per-slot half (0 first, 1 second) |
| wr_kind | output | PORTS*2 | Per-slot request kind |
| scfail_valid | output | 1 | A store-conditional failed last cycle |
| scfail_idx | output | IW | Index of that store-conditional |
| sq_head | output | IW | Head index |
| sq_count | output | IW+1 | Entries held |
| wb_pending | output | IW+1 | Flagged entries not yet completed |

## Verification
A drain pointer that slips past a flagged entry shows up as a missing or out-of-order index on `wr_idx` within the same cycle. A lost pending second half shows up as an `sq_count` that never returns to zero. A corrupted retry register shows up at the next `retry` cycle as the wrong index or half in slot 0. A wrong head walk or pending count shows up on `sq_count` and `wb_pending` on the completion edge itself, because retirement happens in the same cycle as completion. The directed scenarios drain to empty after each case, so any leftover state also shows up at the start of the next scenario.

// File: rtl/sqwb_pkg.sv
package sqwb_pkg;

    typedef enum logic [1:0] {
        RQ_WRITE = 2'b00,
        RQ_COND  = 2'b01,
        RQ_SWAP  = 2'b10
    } rq_kind_e;

    typedef struct packed {
        logic zero;
        logic split;
        logic pf;
        logic cond;
        logic swap;
    } st_attr_t;

    function automatic logic [1:0] kind_of(input st_attr_t a);
        if (a.cond)      return RQ_COND;
        else if (a.swap) return RQ_SWAP;
        else             return RQ_WRITE;
    endfunction

endpackage

// File: rtl/sqwb_mark.sv
module sqwb_mark #(
    parameter int DEPTH = 8,
    parameter int SEQW  = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic                       commit_v,
    input  logic [SEQW-1:0]            commit_seq,
    input  logic [PW-1:0]              head,
    input  logic [PW-1:0]              tail,
    input  logic [DEPTH-1:0]           canwb,
    input  logic [DEPTH-1:0][SEQW-1:0] seq,
    output logic [DEPTH-1:0]           mark,
    output logic [PW-1:0]              n_mark
);
    localparam logic [PW-1:0] ONE_P = 1;

    logic          go;
    logic [PW-1:0] p;

    always_comb begin
        mark   = '0;
        n_mark = '0;
        go     = commit_v;
        p      = head;
        for (int it = 0; it < DEPTH; it++) begin
            if (go && p != tail) begin
                if (!canwb[p[IW-1:0]]) begin
                    if (seq[p[IW-1:0]] > commit_seq) begin
                        go = 1'b0;
                    end else begin
                        mark[p[IW-1:0]] = 1'b1;
                        n_mark = n_mark + ONE_P;
                    end
                end
                p = p + ONE_P;
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sqwb_issue.sv
module sqwb_issue import sqwb_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int PORTS = 2,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1,
    localparam int SW   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                       busy,
    input  logic                       link_ok,
    input  logic                       retry,
    input  logic [PORTS-1:0]           acc,
    input  logic [PW-1:0]              wb,
    input  logic [PW-1:0]              tail,
    input  logic [PW-1:0]              pcnt,
    input  logic [DEPTH-1:0]           canwb,
    input  st_attr_t [DEPTH-1:0]       attr,
    input  logic                       blk_q,
    input  logic [IW-1:0]              rty_idx_q,
    input  logic                       rty_half_q,
    input  logic                       pend_q,
    input  logic [IW-1:0]              pend_idx_q,
    output logic [PORTS-1:0]           req_v,
    output logic [PORTS-1:0][IW-1:0]   req_idx,
    output logic [PORTS-1:0]           req_half,
    output logic [PORTS-1:0][1:0]      req_kind,
    output logic [DEPTH-1:0]           done,
    output logic [PW-1:0]              wb_n,
    output logic                       blk_n,
    output logic [IW-1:0]              rty_idx_n,
    output logic                       rty_half_n,
    output logic                       pend_n,
    output logic [IW-1:0]              pend_idx_n,
    output logic                       scf_v,
    output logic [IW-1:0]              scf_idx
);
    localparam logic [PW-1:0] ONE_P  = 1;
    localparam logic [SW:0]   ONE_U  = 1;
    localparam logic [SW:0]   NPORT  = PORTS[SW:0];

    logic [SW:0]   used;
    logic [SW-1:0] slot;
    logic          run;
    logic [IW-1:0] e;

    always_comb begin
        req_v      = '0;
        req_idx    = '0;
        req_half   = '0;
        req_kind   = '0;
        done       = '0;
        wb_n       = wb;
        blk_n      = blk_q;
        rty_idx_n  = rty_idx_q;
        rty_half_n = rty_half_q;
        pend_n     = pend_q;
        pend_idx_n = pend_idx_q;
        scf_v      = 1'b0;
        scf_idx    = '0;
        used       = '0;
        slot       = '0;
        e          = '0;
        run        = !busy;

        // parked request first, only on a retry cycle
        if (run && blk_q) begin
            if (retry) begin
                req_v[0]    = 1'b1;
                req_idx[0]  = rty_idx_q;
                req_half[0] = rty_half_q;
                req_kind[0] = kind_of(attr[rty_idx_q]);
                used        = ONE_U;
                if (acc[0]) begin
                    blk_n = 1'b0;
                    if (!rty_half_q && attr[rty_idx_q].split) begin
                        pend_n     = 1'b1;
                        pend_idx_n = rty_idx_q;
                    end else begin
                        done[rty_idx_q] = 1'b1;
                    end
                end else begin
                    run = 1'b0;
                end
            end else begin
                run = 1'b0;
            end
        end

        // held second half goes ahead of new entries
        if (run && pend_n) begin
            if (used < NPORT) begin
                slot           = used[SW-1:0];
                used           = used + ONE_U;
                req_v[slot]    = 1'b1;
                req_idx[slot]  = pend_idx_n;
                req_half[slot] = 1'b1;
                req_kind[slot] = kind_of(attr[pend_idx_n]);
                pend_n         = 1'b0;
                if (acc[slot]) begin
                    done[pend_idx_n] = 1'b1;
                end else begin
                    blk_n      = 1'b1;
                    rty_idx_n  = pend_idx_n;
                    rty_half_n = 1'b1;
                    run        = 1'b0;
                end
            end else begin
                run = 1'b0;
            end
        end

        // in-order walk of flagged entries
        for (int it = 0; it < DEPTH; it++) begin
            if (run) begin
                e = wb_n[IW-1:0];
                if (pcnt == '0 || wb_n == tail || !canwb[e]) begin
                    run = 1'b0;
                end else if (attr[e].zero) begin
                    done[e] = 1'b1;
                    wb_n    = wb_n + ONE_P;
                end else if (used >= NPORT) begin
                    run = 1'b0;
                end else begin
                    slot = used[SW-1:0];
                    used = used + ONE_U;
                    wb_n = wb_n + ONE_P;
                    if (attr[e].pf) begin
                        done[e] = 1'b1;
                    end else if (attr[e].cond && !link_ok) begin
                        done[e] = 1'b1;
                        scf_v   = 1'b1;
                        scf_idx = e;
                        run     = 1'b0;
                    end else begin
                        req_v[slot]    = 1'b1;
                        req_idx[slot]  = e;
                        req_half[slot] = 1'b0;
                        req_kind[slot] = kind_of(attr[e]);
                        if (!acc[slot]) begin
                            blk_n      = 1'b1;
                            rty_idx_n  = e;
                            rty_half_n = 1'b0;
                            run        = 1'b0;
                        end else if (attr[e].split) begin
                            if (used < NPORT) begin
                                slot           = used[SW-1:0];
                                used           = used + ONE_U;
                                req_v[slot]    = 1'b1;
                                req_idx[slot]  = e;
                                req_half[slot] = 1'b1;
                                req_kind[slot] = kind_of(attr[e]);
                                if (acc[slot]) begin
                                    done[e] = 1'b1;
                                end else begin
                                    blk_n      = 1'b1;
                                    rty_idx_n  = e;
                                    rty_half_n = 1'b1;
                                    run        = 1'b0;
                                end
                            end else begin
                                pend_n     = 1'b1;
                                pend_idx_n = e;
                                run        = 1'b0;
                            end
                        end else begin
                            done[e] = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sqwb_retire.sv
module sqwb_retire #(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic [PW-1:0]    head,
    input  logic [PW-1:0]    tail,
    input  logic [DEPTH-1:0] done_all,
    output logic [PW-1:0]    head_n,
    output logic [DEPTH-1:0] clr
);
    localparam logic [PW-1:0] ONE_P = 1;

    logic go;

    always_comb begin
        head_n = head;
        clr    = '0;
        go     = 1'b1;
        for (int it = 0; it < DEPTH; it++) begin
            if (go && head_n != tail && done_all[head_n[IW-1:0]]) begin
                clr[head_n[IW-1:0]] = 1'b1;
                head_n = head_n + ONE_P;
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sqwb_engine.sv
module sqwb_engine import sqwb_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int PORTS = 2,
    parameter int SEQW  = 16,
    parameter int SZW   = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_valid,
    input  logic [SEQW-1:0]     alloc_seq,
    input  logic [SZW-1:0]      alloc_size,
    input  logic                alloc_split,
    input  logic                alloc_prefetch,
    input  logic                alloc_cond,
    input  logic                alloc_swap,
    output logic                sq_full,
    input  logic                commit_valid,
    input  logic [SEQW-1:0]     commit_seq,
    input  logic                cache_busy,
    input  logic                link_ok,
    input  logic                retry,
    input  logic [PORTS-1:0]    wr_accept,
    output logic [PORTS-1:0]    wr_valid,
    output logic [PORTS*IW-1:0] wr_idx,
    output logic [PORTS-1:0]    wr_half,
    output logic [PORTS*2-1:0]  wr_kind,
    output logic                scfail_valid,
    output logic [IW-1:0]       scfail_idx,
    output logic [IW-1:0]       sq_head,
    output logic [PW-1:0]       sq_count,
    output logic [PW-1:0]       wb_pending
);
    localparam logic [PW-1:0] ONE_P   = 1;
    localparam logic [PW-1:0] DEPTH_P = DEPTH[PW-1:0];

    logic [DEPTH-1:0][SEQW-1:0] seq_q;
    st_attr_t [DEPTH-1:0]       attr_q;
    logic [DEPTH-1:0]           canwb_q, done_q;
    logic [PW-1:0]              head_q, wb_q, tail_q, pcnt_q;
    logic                       blk_q, rty_half_q, pend_q, scf_v_q;
    logic [IW-1:0]              rty_idx_q, pend_idx_q, scf_idx_q;

    logic [DEPTH-1:0]           mark, cdone, clr;
    logic [PW-1:0]              n_mark, n_done, head_n, wb_n;
    logic                       blk_n, rty_half_n, pend_n, scf_v;
    logic [IW-1:0]              rty_idx_n, pend_idx_n, scf_idx;
    logic [PORTS-1:0]           req_v, req_half;
    logic [PORTS-1:0][IW-1:0]   req_idx;
    logic [PORTS-1:0][1:0]      req_kind;
    logic [PW-1:0]              occ;
    logic                       do_alloc;

    assign occ      = tail_q - head_q;
    assign sq_full  = (occ == DEPTH_P);
    assign do_alloc = alloc_valid && !sq_full;

    sqwb_mark #(.DEPTH(DEPTH), .SEQW(SEQW)) u_mark (
        .commit_v(commit_valid), .commit_seq(commit_seq),
        .head(head_q), .tail(tail_q), .canwb(canwb_q), .seq(seq_q),
        .mark(mark), .n_mark(n_mark)
    );

    sqwb_issue #(.DEPTH(DEPTH), .PORTS(PORTS)) u_issue (
        .busy(cache_busy), .link_ok(link_ok), .retry(retry), .acc(wr_accept),
        .wb(wb_q), .tail(tail_q), .pcnt(pcnt_q), .canwb(canwb_q), .attr(attr_q),
        .blk_q(blk_q), .rty_idx_q(rty_idx_q), .rty_half_q(rty_half_q),
        .pend_q(pend_q), .pend_idx_q(pend_idx_q),
        .req_v(req_v), .req_idx(req_idx), .req_half(req_half), .req_kind(req_kind),
        .done(cdone), .wb_n(wb_n), .blk_n(blk_n), .rty_idx_n(rty_idx_n),
        .rty_half_n(rty_half_n), .pend_n(pend_n), .pend_idx_n(pend_idx_n),
        .scf_v(scf_v), .scf_idx(scf_idx)
    );

    sqwb_retire #(.DEPTH(DEPTH)) u_retire (
        .head(head_q), .tail(tail_q), .done_all(done_q | cdone),
        .head_n(head_n), .clr(clr)
    );

    always_comb begin
        n_done = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cdone[i]) n_done = n_done + ONE_P;
        end
    end

    for (genvar k = 0; k < PORTS; k++) begin : g_port
        assign wr_idx[k*IW +: IW] = req_idx[k];
        assign wr_kind[k*2 +: 2]  = req_kind[k];
    end

    assign wr_valid     = req_v;
    assign wr_half      = req_half;
    assign scfail_valid = scf_v_q;
    assign scfail_idx   = scf_idx_q;
    assign sq_head      = head_q[IW-1:0];
    assign sq_count     = occ;
    assign wb_pending   = pcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q      <= '0;
            attr_q     <= '0;
            canwb_q    <= '0;
            done_q     <= '0;
            head_q     <= '0;
            wb_q       <= '0;
            tail_q     <= '0;
            pcnt_q     <= '0;
            blk_q      <= 1'b0;
            rty_idx_q  <= '0;
            rty_half_q <= 1'b0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            scf_v_q    <= 1'b0;
            scf_idx_q  <= '0;
        end else begin
            canwb_q    <= (canwb_q | mark) & ~clr;
            done_q     <= (done_q | cdone) & ~clr;
            head_q     <= head_n;
            wb_q       <= wb_n;
            pcnt_q     <= pcnt_q + n_mark - n_done;
            blk_q      <= blk_n;
            rty_idx_q  <= rty_idx_n;
            rty_half_q <= rty_half_n;
            pend_q     <= pend_n;
            pend_idx_q <= pend_idx_n;
            scf_v_q    <= scf_v;
            scf_idx_q  <= scf_idx;
            if (do_alloc) begin
                seq_q[tail_q[IW-1:0]]   <= alloc_seq;
                attr_q[tail_q[IW-1:0]]  <= '{zero:  (alloc_size == '0),
                                             split: alloc_split,
                                             pf:    alloc_prefetch,
                                             cond:  alloc_cond,
                                             swap:  alloc_swap};
                canwb_q[tail_q[IW-1:0]] <= 1'b0;
                done_q[tail_q[IW-1:0]]  <= 1'b0;
                tail_q                  <= tail_q + ONE_P;
            end
        end
    end
endmodule

// File: rtl/sqwb_chk.sv
module sqwb_chk #(
    parameter int DEPTH = 8,
    parameter int PORTS = 2,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cache_busy,
    input logic             retry,
    input logic             alloc_valid,
    input logic             sq_full,
    input logic             blocked,
    input logic [PORTS-1:0] wr_valid,
    input logic [PW-1:0]    sq_count,
    input logic [PW-1:0]    wb_pending
);
    localparam logic [PW-1:0] DEPTH_P = DEPTH[PW-1:0];

    a_r7_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        cache_busy |-> wr_valid == '0);

    a_r8_parked_quiet: assert property (@(posedge clk) disable iff (rst)
        (blocked && !retry) |-> wr_valid == '0);

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        sq_count <= DEPTH_P);

    a_r1_full_no_grow: assert property (@(posedge clk) disable iff (rst)
        (sq_full && alloc_valid) |=> sq_count <= $past(sq_count));

    a_r10_pending_bound: assert property (@(posedge clk) disable iff (rst)
        wb_pending <= sq_count);
endmodule

bind sqwb_engine sqwb_chk #(.DEPTH(DEPTH), .PORTS(PORTS)) u_chk (
    .clk(clk), .rst(rst), .cache_busy(cache_busy), .retry(retry),
    .alloc_valid(alloc_valid), .sq_full(sq_full), .blocked(blk_q),
    .wr_valid(wr_valid), .sq_count(sq_count), .wb_pending(wb_pending)
);

// File: tb/sqwb_engine_tb.sv
`timescale 1ns/1ps
module sqwb_engine_tb;
    localparam int DEPTH = 8;
    localparam int PORTS = 2;
    localparam int SEQW  = 16;
    localparam int SZW   = 4;
    localparam int IW    = 3;
    localparam int PW    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 1'b0;
    logic [SEQW-1:0] alloc_seq = '0;
    logic [SZW-1:0] alloc_size = '0;
    logic alloc_split = 1'b0, alloc_prefetch = 1'b0, alloc_cond = 1'b0, alloc_swap = 1'b0;
    logic sq_full;
    logic commit_valid = 1'b0;
    logic [SEQW-1:0] commit_seq = '0;
    logic cache_busy = 1'b0, link_ok = 1'b1, retry = 1'b0;
    logic [PORTS-1:0] wr_accept = '1;
    logic [PORTS-1:0] wr_valid, wr_half;
    logic [PORTS*IW-1:0] wr_idx;
    logic [PORTS*2-1:0] wr_kind;
    logic scfail_valid;
    logic [IW-1:0] scfail_idx, sq_head;
    logic [PW-1:0] sq_count, wb_pending;

    int n_chk = 0;
    int n_bad = 0;
    int b;

    always #2.5 clk = ~clk;

    sqwb_engine #(.DEPTH(DEPTH), .PORTS(PORTS), .SEQW(SEQW), .SZW(SZW)) u_dut (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .alloc_size(alloc_size), .alloc_split(alloc_split), .alloc_prefetch(alloc_prefetch),
        .alloc_cond(alloc_cond), .alloc_swap(alloc_swap), .sq_full(sq_full),
        .commit_valid(commit_valid), .commit_seq(commit_seq), .cache_busy(cache_busy),
        .link_ok(link_ok), .retry(retry), .wr_accept(wr_accept), .wr_valid(wr_valid),
        .wr_idx(wr_idx), .wr_half(wr_half), .wr_kind(wr_kind),
        .scfail_valid(scfail_valid), .scfail_idx(scfail_idx), .sq_head(sq_head),
        .sq_count(sq_count), .wb_pending(wb_pending)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int ix(input int k);
        return k % DEPTH;
    endfunction

    function automatic int slot_idx(input int k);
        return int'(wr_idx[k*IW +: IW]);
    endfunction

    task automatic alloc(input int s, input int sz, input bit sp, input bit pf,
                         input bit cd, input bit sw);
        alloc_seq = SEQW'(s); alloc_size = SZW'(sz); alloc_split = sp;
        alloc_prefetch = pf; alloc_cond = cd; alloc_swap = sw; alloc_valid = 1'b1;
        step();
        alloc_valid = 1'b0; alloc_split = 1'b0; alloc_prefetch = 1'b0;
        alloc_cond = 1'b0; alloc_swap = 1'b0;
    endtask

    task automatic commit(input int s);
        commit_seq = SEQW'(s); commit_valid = 1'b1;
        step();
        commit_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 count", int'(sq_count), 0);
        chk("R11 valid", int'(wr_valid), 0);
        chk("R11 pending", int'(wb_pending), 0);
        chk("R11 full", int'(sq_full), 0);
        chk("R11 head", int'(sq_head), 0);
        chk("R11 scfail", int'(scfail_valid), 0);
    endtask

    task automatic t_commit_order();
        b = int'(sq_head);
        cache_busy = 1'b1;
        alloc(10, 4, 0, 0, 0, 0);
        alloc(30, 4, 0, 0, 0, 0);
        alloc(20, 4, 0, 0, 0, 0);
        commit(20);
        chk("R2 stop at younger", int'(wb_pending), 1);
        chk("R7 busy no req", int'(wr_valid), 0);
        commit(30);
        chk("R2 second walk", int'(wb_pending), 3);
        step();
        chk("R7 busy no completion", int'(sq_count), 3);
        cache_busy = 1'b0;
        #1;
        chk("R3 two slots", int'(wr_valid), 3);
        chk("R3 slot0 idx", slot_idx(0), ix(b));
        chk("R3 slot1 idx", slot_idx(1), ix(b + 1));
        chk("R3 kind write", int'(wr_kind), 0);
        chk("R3 half zero", int'(wr_half), 0);
        step();
        chk("R10 count after two", int'(sq_count), 1);
        chk("R10 pending after two", int'(wb_pending), 1);
        chk("R3 third next cycle", slot_idx(0), ix(b + 2));
        step();
        chk("R10 drained", int'(sq_count), 0);
        chk("R10 pending drained", int'(wb_pending), 0);
    endtask

    task automatic t_unmarked();
        b = int'(sq_head);
        alloc(40, 4, 0, 0, 0, 0);
        step();
        chk("R2 unflagged no req", int'(wr_valid), 0);
        commit(40);
        chk("R2 flagged issues", int'(wr_valid), 1);
        step();
        chk("R2 drained", int'(sq_count), 0);
    endtask

    task automatic t_zero();
        b = int'(sq_head);
        alloc(50, 0, 0, 0, 0, 0);
        alloc(51, 4, 0, 0, 0, 0);
        alloc(52, 4, 0, 0, 0, 0);
        commit(52);
        chk("R4 both slots used", int'(wr_valid), 3);
        chk("R4 skip slot0", slot_idx(0), ix(b + 1));
        chk("R4 skip slot1", slot_idx(1), ix(b + 2));
        step();
        chk("R4 all retired", int'(sq_count), 0);
    endtask

    task automatic t_prefetch();
        b = int'(sq_head);
        alloc(60, 4, 0, 1, 0, 0);
        alloc(61, 4, 0, 0, 0, 0);
        commit(61);
        chk("R5 slot0 consumed", int'(wr_valid), 2);
        chk("R5 slot1 idx", slot_idx(1), ix(b + 1));
        step();
        chk("R5 retired", int'(sq_count), 0);
    endtask

    task automatic t_split();
        b = int'(sq_head);
        alloc(70, 8, 1, 0, 0, 0);
        commit(70);
        chk("R6 two halves", int'(wr_valid), 3);
        chk("R6 same idx", slot_idx(1), ix(b));
        chk("R6 half order", int'(wr_half), 2);
        step();
        chk("R6 split retired", int'(sq_count), 0);
        b = int'(sq_head);
        alloc(71, 4, 0, 0, 0, 0);
        alloc(72, 8, 1, 0, 0, 0);
        alloc(73, 4, 0, 0, 0, 0);
        commit(73);
        chk("R6 first halves", int'(wr_half), 0);
        chk("R6 split in slot1", slot_idx(1), ix(b + 1));
        step();
        chk("R6 split held", int'(sq_count), 2);
        chk("R6 held half first", slot_idx(0), ix(b + 1));
        chk("R6 held half bits", int'(wr_half), 1);
        chk("R6 then next entry", slot_idx(1), ix(b + 2));
        step();
        chk("R6 drained", int'(sq_count), 0);
    endtask

    task automatic t_reject();
        b = int'(sq_head);
        alloc(80, 4, 0, 0, 0, 0);
        alloc(81, 4, 0, 0, 0, 0);
        commit(81);
        wr_accept = 2'b10;
        #1;
        chk("R8 later slot dropped", int'(wr_valid), 1);
        step();
        wr_accept = 2'b11;
        #1;
        chk("R8 parked no req", int'(wr_valid), 0);
        chk("R8 not completed", int'(sq_count), 2);
        step();
        chk("R8 still parked", int'(wr_valid), 0);
        retry = 1'b1;
        #1;
        chk("R8 retry slots", int'(wr_valid), 3);
        chk("R8 retry idx", slot_idx(0), ix(b));
        chk("R8 resume idx", slot_idx(1), ix(b + 1));
        step();
        retry = 1'b0;
        chk("R8 drained", int'(sq_count), 0);
    endtask

    task automatic t_cond();
        b = int'(sq_head);
        link_ok = 1'b0;
        alloc(90, 4, 0, 0, 1, 0);
        alloc(91, 4, 0, 0, 0, 0);
        commit(91);
        chk("R9 no request", int'(wr_valid), 0);
        step();
        chk("R9 fail flag", int'(scfail_valid), 1);
        chk("R9 fail idx", int'(scfail_idx), ix(b));
        chk("R9 completed", int'(sq_count), 1);
        chk("R9 next entry", slot_idx(0), ix(b + 1));
        step();
        chk("R9 flag pulse", int'(scfail_valid), 0);
        chk("R9 drained", int'(sq_count), 0);
        link_ok = 1'b1;
        b = int'(sq_head);
        alloc(92, 4, 0, 0, 1, 0);
        alloc(93, 4, 0, 0, 0, 1);
        commit(93);
        chk("R3 kinds cond swap", int'(wr_kind), 9);
        step();
        chk("R3 drained", int'(sq_count), 0);
    endtask

    task automatic t_full();
        cache_busy = 1'b1;
        for (int i = 0; i < DEPTH; i++) alloc(100 + i, 4, 0, 0, 0, 0);
        chk("R1 full flag", int'(sq_full), 1);
        alloc(120, 4, 0, 0, 0, 0);
        chk("R1 full ignored", int'(sq_count), DEPTH);
        commit(119);
        chk("R7 busy hold", int'(sq_count), DEPTH);
        chk("R2 all flagged", int'(wb_pending), DEPTH);
        cache_busy = 1'b0;
        for (int i = 0; i < 4; i++) step();
        chk("R10 full drain", int'(sq_count), 0);
        chk("R10 pending zero", int'(wb_pending), 0);
        chk("R1 not full", int'(sq_full), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_commit_order();
        t_unmarked();
        t_zero();
        t_prefetch();
        t_split();
        t_reject();
        t_cond();
        t_full();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule